// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Inputs

The controller gathers interrupt request lines from a set of devices and shows the processor one interrupt at a time: the most urgent one that is pending. Each interrupt carries a vector number that names the device that raised it. A request is latched as pending on the rising edge of its line. It stays pending until the processor acknowledges that exact vector.

Ordinary (maskable) requests are subject to a global enable input that the processor drives. While the enable is low, maskable requests are not dropped. They stay pending and appear as soon as the enable returns. A separate group of non-maskable inputs is meant for serious faults such as a power-loss warning or an uncorrectable memory error. These inputs ignore the enable and always outrank every maskable source.

Vectors run from 0 to N_NMI-1 for the non-maskable inputs and from N_NMI to N_NMI+N_MASK-1 for the maskable inputs. A lower vector always means a higher priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no requests, irq_o, nmi_o and vec_o are all 0.
- R2: A pending bit is set only by a 0-to-1 transition of its request line, as seen between consecutive clock edges. A line held high after its vector is acknowledged does not become pending again.
- R3: Among pending maskable inputs, the lowest index wins. It is presented with vec_o = N_NMI + index and nmi_o = 0.
- R4: Whenever any non-maskable request is pending, the lowest-index one is presented with vec_o = index and nmi_o = 1. This holds regardless of any maskable requests.
- R5: While int_en_i is low, no maskable vector is presented.
- R6: A maskable request that arrives while int_en_i is low stays pending. It is presented once int_en_i is high.
- R7: Non-maskable requests are presented whatever the value of int_en_i.
- R8: With ack_i high, the pending bit of vector ack_vec_i is cleared at that clock edge, and no other pending bit changes. A new rising edge in the same cycle sets the bit again.
- R9: A presented interrupt stays, with the same vector, until it is acknowledged. The vector changes earlier only when a higher-priority (lower) vector becomes pending, or when int_en_i drops while a maskable vector is shown.
- R10: The outputs update at the same clock edge that samples the triggering input change (request edge, enable or acknowledge). When nothing is presented, irq_o = 0, nmi_o = 0 and vec_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_MASK | Maskable request lines, index 0 has the highest priority |
| nmi_req_i | input | N_NMI | Non-maskable request lines, index 0 has the highest priority |
| int_en_i | input | 1 | Global enable for the maskable requests |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| ack_vec_i | input | VEC_W | Vector being acknowledged |
| irq_o | output | 1 | Interrupt presented to the processor |
| vec_o | output | VEC_W | Vector of the presented interrupt |
| nmi_o | output | 1 | Presented interrupt is non-maskable |

## Verification
Some properties are checked on every cycle:
- A pending non-maskable request always reaches the outputs.
- A maskable vector is shown only when the enable was high.
- A presented vector never moves to a lower priority without an acknowledge.
- Pending bits survive until their own acknowledge.
- An acknowledged line held high is not latched again.
- The picker's choice is the lowest set bit.

Other behaviours need the bench's scenarios and its reference model. These are the exact vector numbers and the same-edge timing, deferred delivery when the enable returns, and acknowledges that name a vector other than the presented one.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // index width for n items, never below 1
  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] pend_nxt_o
);
  logic [W-1:0] req_q;
  logic [W-1:0] rise;

  assign rise       = req_i & ~req_q;
  // a fresh edge wins over a clear in the same cycle
  assign pend_nxt_o = (pend_o & ~clr_i) | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= pend_nxt_o;
    end
  end

  assert_pend_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(pend_o & ~clr_i)) == $past(pend_o & ~clr_i)));

  assert_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(clr_i & ~rise)) == '0));

  assert_no_relatch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(clr_i & req_i & req_q)) == '0));
endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [W-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  assign valid_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  logic [W-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < W; i++) below_mask[i] = (i < int'(idx_o));
  end

  always_comb begin
    if (valid_o) begin
      assert_lowest_pick_R3: assert (req_i[idx_o] && ((req_i & below_mask) == '0));
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_MASK = 8,
  parameter int unsigned N_NMI  = 2,
  parameter int unsigned VEC_W  = idx_bits(N_MASK + N_NMI)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MASK-1:0] irq_req_i,
  input  logic [N_NMI-1:0]  nmi_req_i,
  input  logic              int_en_i,
  input  logic              ack_i,
  input  logic [VEC_W-1:0]  ack_vec_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              nmi_o
);
  localparam int unsigned MI_W = idx_bits(N_MASK);
  localparam int unsigned NI_W = idx_bits(N_NMI);

  logic [N_MASK-1:0] mask_clr, mask_pend, mask_nxt;
  logic [N_NMI-1:0]  nmi_clr, nmi_pend, nmi_nxt;
  logic              mask_v, nmi_v;
  logic [MI_W-1:0]   mask_idx;
  logic [NI_W-1:0]   nmi_idx;

  for (genvar k = 0; k < N_NMI; k++) begin : g_nmi_ack
    assign nmi_clr[k] = ack_i && (ack_vec_i == VEC_W'(k));
  end
  for (genvar i = 0; i < N_MASK; i++) begin : g_mask_ack
    assign mask_clr[i] = ack_i && (ack_vec_i == VEC_W'(N_NMI + i));
  end

  irq_pend_bank #(.W(N_NMI)) u_nmi_bank (
    .clk_i, .rst_ni, .req_i(nmi_req_i), .clr_i(nmi_clr),
    .pend_o(nmi_pend), .pend_nxt_o(nmi_nxt)
  );
  irq_pend_bank #(.W(N_MASK)) u_mask_bank (
    .clk_i, .rst_ni, .req_i(irq_req_i), .clr_i(mask_clr),
    .pend_o(mask_pend), .pend_nxt_o(mask_nxt)
  );

  irq_first_pick #(.W(N_NMI), .IW(NI_W)) u_nmi_pick (
    .req_i(nmi_nxt), .valid_o(nmi_v), .idx_o(nmi_idx)
  );
  irq_first_pick #(.W(N_MASK), .IW(MI_W)) u_mask_pick (
    .req_i(mask_nxt), .valid_o(mask_v), .idx_o(mask_idx)
  );

  logic             irq_d, nmi_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    irq_d = 1'b0;
    nmi_d = 1'b0;
    vec_d = '0;
    if (nmi_v) begin
      irq_d = 1'b1;
      nmi_d = 1'b1;
      vec_d = VEC_W'(nmi_idx);
    end else if (int_en_i && mask_v) begin
      irq_d = 1'b1;
      vec_d = VEC_W'(N_NMI) + VEC_W'(mask_idx);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      nmi_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= irq_d;
      nmi_o <= nmi_d;
      vec_o <= vec_d;
    end
  end

  assert_nmi_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nmi_pend) |-> (irq_o && nmi_o && (vec_o < VEC_W'(N_NMI))));

  assert_masked_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !nmi_o) |-> $past(int_en_i));

  assert_deferred_shown_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|mask_pend) && $past(int_en_i)) |-> irq_o);

  assert_vec_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i && (nmi_o || int_en_i)) |=> (irq_o && (vec_o <= $past(vec_o))));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int unsigned N_MASK = 8;
  localparam int unsigned N_NMI  = 2;
  localparam int unsigned VEC_W  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_MASK-1:0] irq_req_i = '0;
  logic [N_NMI-1:0]  nmi_req_i = '0;
  logic              int_en_i = 1'b0;
  logic              ack_i = 1'b0;
  logic [VEC_W-1:0]  ack_vec_i = '0;
  logic              irq_o, nmi_o;
  logic [VEC_W-1:0]  vec_o;

  int unsigned total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl #(.N_MASK(N_MASK), .N_NMI(N_NMI), .VEC_W(VEC_W)) u_prio_irq_ctrl (
    .clk_i, .rst_ni, .irq_req_i, .nmi_req_i, .int_en_i, .ack_i, .ack_vec_i,
    .irq_o, .vec_o, .nmi_o
  );

  // reference model state
  logic [N_MASK-1:0] m_prev = '0, m_pend = '0;
  logic [N_NMI-1:0]  n_prev = '0, n_pend = '0;
  logic              e_irq = 0, e_nmi = 0;
  logic [VEC_W-1:0]  e_vec = '0;

  function automatic int first_set_m(logic [N_MASK-1:0] v);
    for (int i = 0; i < N_MASK; i++) if (v[i]) return i;
    return -1;
  endfunction
  function automatic int first_set_n(logic [N_NMI-1:0] v);
    for (int i = 0; i < N_NMI; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_edge();
    logic [N_MASK-1:0] mc;
    logic [N_NMI-1:0]  nc;
    mc = '0; nc = '0;
    if (ack_i) begin
      if (int'(ack_vec_i) < N_NMI) nc[ack_vec_i] = 1'b1;
      else if (int'(ack_vec_i) < N_NMI + N_MASK) mc[int'(ack_vec_i) - N_NMI] = 1'b1;
    end
    m_pend = (m_pend & ~mc) | (irq_req_i & ~m_prev);
    n_pend = (n_pend & ~nc) | (nmi_req_i & ~n_prev);
    m_prev = irq_req_i;
    n_prev = nmi_req_i;
    e_irq = 0; e_nmi = 0; e_vec = '0;
    if (n_pend != 0) begin
      e_irq = 1; e_nmi = 1; e_vec = VEC_W'(first_set_n(n_pend));
    end else if (int_en_i && m_pend != 0) begin
      e_irq = 1; e_vec = VEC_W'(N_NMI + first_set_m(m_pend));
    end
  endtask

  task automatic check(string tag);
    total++;
    if (irq_o !== e_irq || nmi_o !== e_nmi || vec_o !== e_vec) begin
      bad++;
      $display("FAIL %s: got irq=%0b nmi=%0b vec=%0d exp irq=%0b nmi=%0b vec=%0d",
               tag, irq_o, nmi_o, vec_o, e_irq, e_nmi, e_vec);
    end
  endtask

  // inputs set at negedge, model follows the posedge, compare at next negedge
  task automatic step(logic [N_MASK-1:0] m, logic [N_NMI-1:0] n, logic en,
                      logic ak, logic [VEC_W-1:0] av, string tag);
    irq_req_i = m; nmi_req_i = n; int_en_i = en; ack_i = ak; ack_vec_i = av;
    @(posedge clk_i);
    #1 model_edge();
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N_MASK-1:0] m;
    logic [N_NMI-1:0]  n;
    logic en, ak;
    logic [VEC_W-1:0] av;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1 in reset");
    rst_ni = 1'b1;
    step('0, '0, 0, 0, '0, "R1 idle after reset");
    step('0, '0, 1, 0, '0, "R1 idle enabled");
    // masked arrival, then deferred delivery
    step(8'h08, '0, 0, 0, '0, "R5 masked line 3");
    step(8'h08, '0, 0, 0, '0, "R5 still masked");
    step(8'h08, '0, 1, 0, '0, "R6 delivered on enable");
    // lower-index arrival preempts
    step(8'h0A, '0, 1, 0, '0, "R3 line 1 preempts");
    step(8'h0A, '0, 1, 0, '0, "R9 hold without ack");
    // ack of a non-presented vector clears only that one
    step(8'h0A, '0, 1, 1, VEC_W'(N_NMI + 3), "R8 ack other vector");
    step(8'h0A, '0, 1, 1, VEC_W'(N_NMI + 1), "R8 ack presented");
    step(8'h0A, '0, 1, 0, '0, "R2 held lines no relatch");
    // NMI ignores the mask and beats maskable
    step(8'h01, '0, 0, 0, '0, "R5 line 0 masked");
    step(8'h01, 2'b10, 0, 0, '0, "R7 nmi while masked");
    step(8'h01, 2'b10, 1, 0, '0, "R4 nmi beats maskable");
    step(8'h01, 2'b11, 1, 0, '0, "R4 nmi 0 preempts nmi 1");
    step(8'h01, 2'b11, 1, 1, VEC_W'(0), "R8 ack nmi 0");
    step(8'h01, 2'b11, 1, 1, VEC_W'(1), "R8 ack nmi 1");
    step(8'h00, 2'b00, 0, 0, '0, "R5 drop enable withdraws");
    step(8'h00, 2'b00, 1, 0, '0, "R6 reappears");
    // ack and new edge together: edge wins
    step(8'h01, 2'b00, 1, 1, VEC_W'(N_NMI), "R8 set beats clear");
    step(8'h00, 2'b00, 1, 1, VEC_W'(N_NMI), "R8 final ack");
    step(8'h80, 2'b00, 1, 0, '0, "R3 highest index line");
    step(8'h80, 2'b00, 1, 1, VEC_W'(N_NMI + 7), "R10 idle vector zero");
    // random phase
    m = '0; n = '0; en = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < N_MASK; b++) if ($urandom_range(7) == 0) m[b] = ~m[b];
      for (int b = 0; b < N_NMI; b++) if ($urandom_range(39) == 0) n[b] = ~n[b];
      if ($urandom_range(19) == 0) en = ~en;
      ak = 1'b0; av = '0;
      if (irq_o && $urandom_range(2) == 0) begin ak = 1'b1; av = vec_o; end
      else if ($urandom_range(9) == 0) begin ak = 1'b1; av = VEC_W'($urandom_range(N_NMI + N_MASK - 1)); end
      step(m, n, en, ak, av, "random R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule